// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is the address and command register of a memory module. On every rising clock edge it captures a set of command and address bits and drives them out as registered outputs. Two static configuration pins pick how the inputs map to the outputs. The first pin chooses between a 25-lane one-to-one register and a 14-lane one-to-two register. In the one-to-two register, every captured bit drives an A copy and an identical B copy. The second pin chooses between two lane layouts when the one-to-two register is selected.

Two active-low select inputs gate the ordinary data lanes. When both are high at a clock edge, the data outputs hold their values. The registered select, termination and clock-enable outputs load on every edge and are never held by this gate. An active-low reset, asynchronous to the clock, clears every register and forces every output low. Reset wins over both the gate and the capture.

Lane positions are numbered 1 to 25. Input bit `d_in[p]` feeds output bit `q_a[p]` and output bit `q_b[p]`.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rst_n` is low, every output is 0. Outputs go to 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: With `cfg_split`=0, each rising edge that loads data copies `d_in[p]` into `q_a[p]` for p in {2,3,5,6} and p in 8..25. `odt_qa` and `cke_qa` take `odt_in` and `cke_in`.
- R3: With `cfg_split`=0, the outputs `q_b`, `cs_qb`, `odt_qb` and `cke_qb` are all 0, and `q_a[1]`, `q_a[4]` and `q_a[7]` are 0.
- R4: With `cfg_split`=1 and `cfg_alt`=0, the data lanes are p in {2,3,5,6} and p in 8..14. All other `q_a`/`q_b` positions are 0. `odt_in` and `cke_in` feed the termination and clock-enable outputs.
- R5: With `cfg_split`=1 and `cfg_alt`=1, the data lanes are p in 1..6, p in 8..10, and p in {12,13}. Termination is taken from `d_in[11]` and clock enable from `d_in[14]`. `odt_in` and `cke_in` are ignored. Positions 7, 11 and 14..25 of `q_a`/`q_b` are 0.
- R6: If `cs_a_n` and `cs_b_n` are both 1 at a rising edge, `q_a` and `q_b` keep their previous values.
- R7: If either `cs_a_n` or `cs_b_n` is 0 at a rising edge, the data outputs load the newly mapped inputs.
- R8: At every rising edge out of reset, `cs_qa` takes the value of `cs_a_n`, and the termination and clock-enable outputs load their sources, whether or not the data lanes are held.
- R9: Rising edges that occur while `rst_n` is low leave the outputs at 0. After `rst_n` rises, the outputs stay 0 until the first rising edge.
- R10: With `cfg_split`=1, the outputs `q_b`, `cs_qb`, `odt_qb` and `cke_qb` always equal `q_a`, `cs_qa`, `odt_qa` and `cke_qa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg_split | input | 1 | 0: 25-lane one-to-one, 1: 14-lane one-to-two |
| cfg_alt | input | 1 | Layout choice in one-to-two mode (0: layout A, 1: layout B) |
| cs_a_n | input | 1 | Primary active-low select, also registered to `cs_qa` |
| cs_b_n | input | 1 | Secondary active-low select, used only for gating |
| d_in | input | 25 | Lane inputs, positions 25 down to 1 |
| odt_in | input | 1 | Dedicated termination input |
| cke_in | input | 1 | Dedicated clock-enable input |
| q_a | output | 25 | A-copy registered lanes |
| q_b | output | 25 | B-copy registered lanes |
| cs_qa | output | 1 | Registered select, A copy |
| cs_qb | output | 1 | Registered select, B copy |
| odt_qa | output | 1 | Registered termination, A copy |
| odt_qb | output | 1 | Registered termination, B copy |
| cke_qa | output | 1 | Registered clock enable, A copy |
| cke_qb | output | 1 | Registered clock enable, B copy |

## Verification
The properties assume two things about the inputs. First, the configuration pins change only while reset is held. Second, `rst_n` never pulses low and back high between two rising edges, so a one-cycle check is never split by an unseen clear.

The stimulus respects both assumptions. It changes `cfg_split` and `cfg_alt` only inside a reset window. It drives every input on the falling clock edge. It drops or releases reset in the middle of a cycle, so that the asynchronous clear, and the quiet interval before the first edge after release, can be observed apart from any capture.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    // Number of lane positions, numbered 1..NPOS
    localparam int NPOS       = 25;
    // Last lane position used by the 14-lane layouts
    localparam int SPLIT_TOP  = 14;
    // Lane positions that carry termination / clock enable in layout B
    localparam int ODT_SLOT_B = 11;
    localparam int CKE_SLOT_B = 14;
    localparam int CTL_W      = 3;

    typedef enum logic [1:0] {
        MAP_WIDE    = 2'd0,
        MAP_SPLIT_A = 2'd1,
        MAP_SPLIT_B = 2'd2
    } map_e;

    typedef struct packed {
        logic cs;
        logic odt;
        logic cke;
    } ctl_t;

    function automatic map_e pick_map(input logic split, input logic alt);
        if (!split)
            return MAP_WIDE;
        else if (alt)
            return MAP_SPLIT_B;
        return MAP_SPLIT_A;
    endfunction

    // Lanes that carry ordinary data for a given layout
    function automatic logic [NPOS:1] lane_mask(input map_e m);
        logic [NPOS:1] r;
        logic          core;
        r = '0;
        for (int p = 1; p <= NPOS; p++) begin
            core = (p == 2) || (p == 3) || (p == 5) || (p == 6) ||
                   (p >= 8 && p <= 10);
            case (m)
                MAP_WIDE:    r[p] = core || (p >= 11);
                MAP_SPLIT_A: r[p] = core || (p >= 11 && p <= SPLIT_TOP);
                MAP_SPLIT_B: r[p] = core || (p == 1) || (p == 4) ||
                                    (p == 12) || (p == 13);
                default:     r[p] = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cmd_lane_map.sv
module cmd_lane_map
    import cmdbuf_pkg::*;
(
    input  logic            split,
    input  logic            alt,
    input  logic            cs_n,
    input  logic [NPOS:1]   d_in,
    input  logic            odt_in,
    input  logic            cke_in,
    output logic [NPOS:1]   data_next,
    output ctl_t            ctl_next
);

    map_e          map;
    logic [NPOS:1] mask;

    always_comb begin
        map       = pick_map(split, alt);
        mask      = lane_mask(map);
        data_next = d_in & mask;
        ctl_next.cs = cs_n;
        if (map == MAP_SPLIT_B) begin
            ctl_next.odt = d_in[ODT_SLOT_B];
            ctl_next.cke = d_in[CKE_SLOT_B];
        end else begin
            ctl_next.odt = odt_in;
            ctl_next.cke = cke_in;
        end
    end

endmodule

// File: rtl/cmd_hold_reg.sv
module cmd_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W:1]   d,
    output logic [W:1]   q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/cmd_ctl_reg.sv
module cmd_ctl_reg
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t d,
    output ctl_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/cmd_fanout.sv
module cmd_fanout #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] a,
    output logic [W-1:0] b
);

    for (genvar i = 0; i < W; i++) begin : g_copy
        assign b[i] = en & a[i];
    end

endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
    import cmdbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_split,
    input  logic            cfg_alt,
    input  logic            cs_a_n,
    input  logic            cs_b_n,
    input  logic [NPOS:1]   d_in,
    input  logic            odt_in,
    input  logic            cke_in,
    output logic [NPOS:1]   q_a,
    output logic [NPOS:1]   q_b,
    output logic            cs_qa,
    output logic            cs_qb,
    output logic            odt_qa,
    output logic            odt_qb,
    output logic            cke_qa,
    output logic            cke_qb
);

    logic [NPOS:1] data_next;
    logic [NPOS:1] data_q;
    ctl_t          ctl_next;
    ctl_t          ctl_q;
    ctl_t          ctl_b;
    logic          data_load;

    // Data lanes load unless both selects are high
    assign data_load = ~(cs_a_n & cs_b_n);

    cmd_lane_map u_map (
        .split     (cfg_split),
        .alt       (cfg_alt),
        .cs_n      (cs_a_n),
        .d_in      (d_in),
        .odt_in    (odt_in),
        .cke_in    (cke_in),
        .data_next (data_next),
        .ctl_next  (ctl_next)
    );

    cmd_hold_reg #(.W(NPOS)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (data_load),
        .d     (data_next),
        .q     (data_q)
    );

    cmd_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_next),
        .q     (ctl_q)
    );

    cmd_fanout #(.W(NPOS)) u_fan_data (
        .en (cfg_split),
        .a  (data_q),
        .b  (q_b)
    );

    cmd_fanout #(.W(CTL_W)) u_fan_ctl (
        .en (cfg_split),
        .a  (ctl_q),
        .b  (ctl_b)
    );

    assign q_a    = data_q;
    assign cs_qa  = ctl_q.cs;
    assign odt_qa = ctl_q.odt;
    assign cke_qa = ctl_q.cke;
    assign cs_qb  = ctl_b.cs;
    assign odt_qb = ctl_b.odt;
    assign cke_qb = ctl_b.cke;

endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk
    import cmdbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_split,
    input  logic            cfg_alt,
    input  logic            cs_a_n,
    input  logic            cs_b_n,
    input  logic [NPOS:1]   d_in,
    input  logic            odt_in,
    input  logic            cke_in,
    input  logic [NPOS:1]   q_a,
    input  logic [NPOS:1]   q_b,
    input  logic            cs_qa,
    input  logic            cs_qb,
    input  logic            odt_qa,
    input  logic            odt_qb,
    input  logic            cke_qa,
    input  logic            cke_qb
);

    logic b_layout;
    assign b_layout = cfg_split && cfg_alt;

    p_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !cs_qa && !cs_qb &&
                    !odt_qa && !odt_qb && !cke_qa && !cke_qb));

    p_ded_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !b_layout |=> (odt_qa == $past(odt_in) && cke_qa == $past(cke_in)));

    p_wide_b_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_split |-> (q_b == '0 && !cs_qb && !odt_qb && !cke_qb));

    p_lane_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        b_layout |=> (odt_qa == $past(d_in[ODT_SLOT_B]) &&
                      cke_qa == $past(d_in[CKE_SLOT_B])));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n && cs_b_n) |=> $stable(q_a));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_a_n && cs_b_n) |=>
            q_a == ($past(d_in) & lane_mask(pick_map(cfg_split, cfg_alt))));

    p_cs_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cs_qa == $past(cs_a_n));

    p_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_split |-> (q_b == q_a && cs_qb == cs_qa &&
                       odt_qb == odt_qa && cke_qb == cke_qa));

endmodule

bind cmd_regbuf cmd_regbuf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_split (cfg_split),
    .cfg_alt   (cfg_alt),
    .cs_a_n    (cs_a_n),
    .cs_b_n    (cs_b_n),
    .d_in      (d_in),
    .odt_in    (odt_in),
    .cke_in    (cke_in),
    .q_a       (q_a),
    .q_b       (q_b),
    .cs_qa     (cs_qa),
    .cs_qb     (cs_qb),
    .odt_qa    (odt_qa),
    .odt_qb    (odt_qb),
    .cke_qa    (cke_qa),
    .cke_qb    (cke_qb)
);

// File: tb/cmd_regbuf_bench.sv
`timescale 1ns/1ps
module cmd_regbuf_bench;

    localparam int NP      = 25;
    localparam int OBS_W   = 2 * NP + 6;
    localparam int WD_CYC  = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          cfg_split = 1'b0;
    logic          cfg_alt = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b_n = 1'b1;
    logic [NP:1]   d_in = '0;
    logic          odt_in = 1'b0;
    logic          cke_in = 1'b0;
    logic [NP:1]   q_a, q_b;
    logic          cs_qa, cs_qb, odt_qa, odt_qb, cke_qa, cke_qb;

    always #2 clk = ~clk;

    cmd_regbuf u_cmd_regbuf (
        .clk (clk), .rst_n (rst_n), .cfg_split (cfg_split), .cfg_alt (cfg_alt),
        .cs_a_n (cs_a_n), .cs_b_n (cs_b_n), .d_in (d_in),
        .odt_in (odt_in), .cke_in (cke_in),
        .q_a (q_a), .q_b (q_b), .cs_qa (cs_qa), .cs_qb (cs_qb),
        .odt_qa (odt_qa), .odt_qb (odt_qb), .cke_qa (cke_qa), .cke_qb (cke_qb)
    );

    typedef struct {
        logic [OBS_W-1:0] v;
        string            tag;
    } exp_t;

    exp_t        sbq[$];
    int          total = 0;
    int          bad = 0;
    logic [NP:1] model_q = '0;
    bit          finished = 1'b0;

    // Data lanes per layout, built from the requirement lists
    function automatic logic [NP:1] ref_lanes(input logic split, input logic alt);
        logic [NP:1] r;
        r = '0;
        r[2] = 1'b1; r[3] = 1'b1; r[5] = 1'b1; r[6] = 1'b1;
        r[8] = 1'b1; r[9] = 1'b1; r[10] = 1'b1;
        if (!split) begin
            for (int p = 11; p <= NP; p++) r[p] = 1'b1;
        end else if (!alt) begin
            for (int p = 11; p <= 14; p++) r[p] = 1'b1;
        end else begin
            r[1] = 1'b1; r[4] = 1'b1; r[12] = 1'b1; r[13] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [OBS_W-1:0] observed();
        return {q_a, q_b, cs_qa, cs_qb, odt_qa, odt_qb, cke_qa, cke_qb};
    endfunction

    task automatic cmp_out(input exp_t e);
        logic [OBS_W-1:0] act;
        act = observed();
        total++;
        if (act !== e.v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", e.tag, act, e.v, $time);
        end
    endtask

    task automatic chk_zero(input string tag);
        exp_t e;
        e.v = '0;
        e.tag = tag;
        cmp_out(e);
    endtask

    // Apply inputs now and queue the result expected after the next rising edge
    task automatic apply_push(input logic csa, input logic csb, input logic [NP:1] d,
                              input logic odt, input logic cke, input string tag);
        exp_t        e;
        logic        eo, ek;
        cs_a_n = csa; cs_b_n = csb; d_in = d; odt_in = odt; cke_in = cke;
        if (!(csa && csb))
            model_q = d & ref_lanes(cfg_split, cfg_alt);
        if (cfg_split && cfg_alt) begin
            eo = d[11]; ek = d[14];
        end else begin
            eo = odt; ek = cke;
        end
        e.v = {model_q, (cfg_split ? model_q : {NP{1'b0}}),
               csa, cfg_split & csa, eo, cfg_split & eo, ek, cfg_split & ek};
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic drive(input logic csa, input logic csb, input logic [NP:1] d,
                         input logic odt, input logic cke, input string tag);
        @(negedge clk);
        apply_push(csa, csb, d, odt, cke, tag);
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            cmp_out(e);
        end
    end

    // Enter reset mid-cycle, reconfigure, exercise edges under reset, release
    task automatic start_mode(input logic split, input logic alt);
        @(posedge clk);
        #1.5;
        rst_n = 1'b0;
        #0.2;
        chk_zero("R1");
        cfg_split = split;
        cfg_alt   = alt;
        @(negedge clk);
        cs_a_n = 1'b0; cs_b_n = 1'b0; d_in = '1; odt_in = 1'b1; cke_in = 1'b1;
        @(posedge clk);
        #1;
        chk_zero("R9");
        @(negedge clk);
        #0.5;
        rst_n = 1'b1;
        #0.5;
        chk_zero("R9");
        model_q = '0;
        apply_push(1'b0, 1'b1, 25'h0A5_A5A5, 1'b0, 1'b1, "R9");
    endtask

    initial begin
        #0.5 rst_n = 1'b0;

        // one-to-one register
        start_mode(1'b0, 1'b0);
        drive(1'b0, 1'b0, 25'h1F0_F0F5, 1'b1, 1'b0, "R2");
        drive(1'b0, 1'b1, 25'h0C3_3C3C, 1'b0, 1'b1, "R7");
        drive(1'b1, 1'b0, 25'h155_5555, 1'b1, 1'b1, "R7");
        drive(1'b1, 1'b1, 25'h0AA_AAAA, 1'b0, 1'b0, "R6");
        drive(1'b1, 1'b1, 25'h1FF_FFFF, 1'b1, 1'b0, "R8");
        drive(1'b0, 1'b0, 25'h1FF_FFFF, 1'b0, 1'b1, "R3");
        for (int i = 0; i < 20; i++)
            drive(1'(($urandom % 3) == 0), 1'(($urandom % 2) == 0),
                  25'($urandom), 1'($urandom), 1'($urandom), "R2");

        // one-to-two, layout A
        start_mode(1'b1, 1'b0);
        drive(1'b0, 1'b0, 25'h1FF_FFFF, 1'b1, 1'b1, "R4");
        drive(1'b1, 1'b0, 25'h123_4567, 1'b0, 1'b1, "R10");
        drive(1'b1, 1'b1, 25'h0FE_DCBA, 1'b1, 1'b0, "R6");
        drive(1'b1, 1'b1, 25'h000_0000, 1'b0, 1'b1, "R8");
        drive(1'b0, 1'b1, 25'h1E0_3C96, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 20; i++)
            drive(1'(($urandom % 3) == 0), 1'(($urandom % 2) == 0),
                  25'($urandom), 1'($urandom), 1'($urandom), "R10");

        // one-to-two, layout B
        start_mode(1'b1, 1'b1);
        drive(1'b0, 1'b0, 25'h1FF_FFFF, 1'b0, 1'b0, "R5");
        drive(1'b0, 1'b0, 25'h000_2000, 1'b1, 1'b0, "R5");
        drive(1'b1, 1'b1, 25'h000_0400, 1'b0, 1'b1, "R8");
        drive(1'b0, 1'b1, 25'h1FF_B3FF, 1'b1, 1'b1, "R5");
        drive(1'b1, 1'b1, 25'h000_0000, 1'b1, 1'b1, "R6");
        for (int i = 0; i < 20; i++)
            drive(1'(($urandom % 3) == 0), 1'(($urandom % 2) == 0),
                  25'($urandom), 1'($urandom), 1'($urandom), "R7");

        // asynchronous clear with loaded outputs
        start_mode(1'b0, 1'b0);
        @(posedge clk);
        #2;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule